// File: doc/BRIEF.md
# Interlocked Strobe/Acknowledge Transfer Master

This block runs one data transfer at a time on a wide backplane bus that uses an asynchronous four-phase handshake. It assumes the module already owns the bus. A user-side `start` pulse carries a 32-bit address, a direction bit and, for writes, a 128-bit word. The block drives these onto the bus and holds them for a programmable number of clock cycles. It then pulls the active-low strobe down and waits for the slave to pull the active-low acknowledge down. On a read it captures the returned word. It then lifts the strobe and waits until the slave lifts the acknowledge. Only then does it pulse `done` and allow the next cycle.

The acknowledge is asynchronous. It passes through a two-flop synchroniser before the controller sees it. If no acknowledge arrives within a programmable number of cycles after the strobe falls, a shared saturating counter ends the wait. The strobe is then lifted and `done` is reported together with `err`. A bus-clear input takes the strobe and all driven lines away in the same cycle and sends the controller back to idle. A `release_ok` output tells the arbitration logic when the bus can be handed back.

The controller has four states. `ST_IDLE` goes to `ST_SETUP` on `start`. `ST_SETUP` goes to `ST_STROBE` once the setup count has expired and the synchronised acknowledge is high. `ST_STROBE` goes to `ST_UNWIND` either when the acknowledge is seen or when the timeout expires. `ST_UNWIND` goes to `ST_IDLE` once the acknowledge is high again. `bus_clr` forces `ST_IDLE` from every state.

Top module: `sabus_master`

## Requirements
- R1: After reset, `strobe_n` is 1, `bus_drive`, `busy`, `done` and `err` are 0, and `release_ok` is 1 while `ack_n` is high.
- R2: A `start` seen in idle latches the request. From the next clock on, `busy` is 1, `bus_addr` carries the address and `bus_rd` is 1 for a read and 0 for a write. For writes `bus_drive` is 1 and `bus_wdata` carries the word; for reads `bus_drive` is 0 and `bus_wdata` is 0.
- R3: With the acknowledge released, `strobe_n` falls exactly SETUP_CYC clocks after the address appears. Address and direction stay stable while `strobe_n` is low.
- R4: The strobe does not fall while the synchronised acknowledge is still low. If `ack_n` is held low across `start`, the strobe falls on the third clock after `ack_n` rises, or at the normal setup point if that comes later.
- R5: With two synchroniser stages, `strobe_n` rises on the third clock after `ack_n` falls.
- R6: On a read, `rd_data` takes the value of `bus_rdata` at the clock where the acknowledge is recognised. A write leaves `rd_data` unchanged.
- R7: `done` is a one-clock pulse on the third clock after `ack_n` rises. In that same cycle `busy` returns to 0.
- R8: `release_ok` is 1 only in idle, with `strobe_n` high and the synchronised acknowledge high. It is 0 while a slave holds `ack_n` low.
- R9: If no acknowledge is recognised within TIMEOUT_CYC clocks of the strobe falling, `strobe_n` rises after exactly TIMEOUT_CYC clocks low. `done` then pulses with `err` = 1. A successful cycle reports `err` = 0.
- R10: While `bus_clr` is 1, `strobe_n` is 1, and `bus_drive`, `bus_addr` and `bus_rd` are 0, in the same cycle. At the next clock the block is idle (`busy` = 0), and no `done` is produced.
- R11: A `start` while `busy` is 1 is ignored: the bus address of the cycle in flight does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clr | input | 1 | Bus clear: drop strobe and data now, go idle |
| start | input | 1 | Begin one transfer (idle only) |
| req_rd | input | 1 | 1 = read, 0 = write |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 128 | Write word |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | With `done`: cycle ended by timeout |
| rd_data | output | 128 | Last captured read word |
| bus_addr | output | 32 | Bus address lines |
| bus_rd | output | 1 | Bus direction, high for read |
| bus_wdata | output | 128 | Bus data driven on writes |
| bus_drive | output | 1 | Enable for the bus data drivers |
| strobe_n | output | 1 | Active-low data strobe |
| ack_n | input | 1 | Active-low slave completion, asynchronous |
| bus_rdata | input | 128 | Bus data returned on reads |
| release_ok | output | 1 | Safe to hand the bus back |

## Verification
Reads and writes are swept over every slave acknowledge latency from zero up to the last one that still beats the timeout. Each sweep point also varies how long the slave holds the acknowledge. This separates the synchroniser latency (R5, R7) from the setup count (R3), and read capture (R6) from write-data driving (R2). A silent slave exposes the timeout boundary. An acknowledge held low across `start` shows that the setup guard waits for the slave rather than for the counter alone. A mid-cycle bus clear and a stray `start` show the abort path and that requests arriving while busy are ignored.

// File: rtl/sabus_pkg.sv
package sabus_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_UNWIND = 2'd3
    } sabus_state_t;
endpackage

// File: rtl/sabus_sync.sv
module sabus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= d_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/sabus_tick.sv
module sabus_tick #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) cnt <= '0;
        else if (cnt != TOP) cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sabus_master.sv
module sabus_master
    import sabus_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 128,
    parameter int SETUP_CYC   = 2,
    parameter int TIMEOUT_CYC = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clr,
    input  logic              start,
    input  logic              req_rd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_rd,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_drive,
    output logic              strobe_n,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              release_ok
);
    localparam int CNT_MAX = (SETUP_CYC > TIMEOUT_CYC) ? SETUP_CYC : TIMEOUT_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1) + 1;
    localparam logic [CW-1:0] SETUP_LAST = CW'(SETUP_CYC - 1);
    localparam logic [CW-1:0] TMO_LAST   = CW'(TIMEOUT_CYC - 1);

    sabus_state_t state, state_n;
    logic              ack_hi;
    logic              ack_lo;
    logic [CW-1:0]     cnt;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              rd_q;
    logic              tmo_q;

    sabus_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ack_n),
        .q_sync  (ack_hi)
    );
    assign ack_lo = ~ack_hi;

    sabus_tick #(.W(CW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_n != state),
        .cnt   (cnt)
    );

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (start) state_n = ST_SETUP;
            ST_SETUP:  if (cnt >= SETUP_LAST && ack_hi) state_n = ST_STROBE;
            ST_STROBE: if (ack_lo || cnt >= TMO_LAST) state_n = ST_UNWIND;
            ST_UNWIND: if (ack_hi) state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
        if (bus_clr) state_n = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // request, capture and completion registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            rd_q    <= 1'b0;
            tmo_q   <= 1'b0;
            rd_data <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            if (state == ST_IDLE && start && !bus_clr) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                rd_q    <= req_rd;
                tmo_q   <= 1'b0;
            end
            if (state == ST_STROBE && !bus_clr) begin
                if (ack_lo) begin
                    if (rd_q) rd_data <= bus_rdata;
                end else if (cnt >= TMO_LAST) begin
                    tmo_q <= 1'b1;
                end
            end
            if (state == ST_UNWIND && ack_hi && !bus_clr) begin
                done <= 1'b1;
                err  <= tmo_q;
            end
        end
    end

    // bus-side outputs, cut off at once by bus_clr
    always_comb begin
        busy       = (state != ST_IDLE);
        strobe_n   = ~((state == ST_STROBE) && !bus_clr);
        bus_addr   = (busy && !bus_clr) ? addr_q : '0;
        bus_rd     = busy && !bus_clr && rd_q;
        bus_drive  = !bus_clr && !rd_q && (state == ST_SETUP || state == ST_STROBE);
        bus_wdata  = bus_drive ? wdata_q : '0;
        release_ok = (state == ST_IDLE) && ack_hi && !bus_clr;
    end

    // R8
    release_safe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        release_ok |-> (strobe_n && ack_hi));

    // R3
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n && $past(!strobe_n)) |-> ($stable(bus_addr) && $stable(bus_rd)));

    // R4
    no_strobe_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strobe_n) |-> $past(ack_hi));

    // R10
    clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_clr |=> (!busy && !done));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);
endmodule

// File: tb/sabus_master_bench.sv
module sabus_master_bench;
    localparam int SETUP = 2;
    localparam int TMO   = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_clr = 1'b0;
    logic         start = 1'b0;
    logic         req_rd = 1'b0;
    logic [31:0]  req_addr = '0;
    logic [127:0] req_wdata = '0;
    logic         busy, done, err, bus_rd, bus_drive, strobe_n, release_ok;
    logic [127:0] rd_data, bus_wdata;
    logic [31:0]  bus_addr;
    logic         ack_n = 1'b1;
    logic [127:0] bus_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;
    logic [127:0] last_rd = '0;

    always #2.5 clk = ~clk;

    sabus_master #(.SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u_sabus_master (
        .clk(clk), .rst_n(rst_n), .bus_clr(bus_clr), .start(start),
        .req_rd(req_rd), .req_addr(req_addr), .req_wdata(req_wdata),
        .busy(busy), .done(done), .err(err), .rd_data(rd_data),
        .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wdata(bus_wdata),
        .bus_drive(bus_drive), .strobe_n(strobe_n), .ack_n(ack_n),
        .bus_rdata(bus_rdata), .release_ok(release_ok)
    );

    task automatic chk(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    // issue start at a negedge, return at the next negedge
    task automatic issue(input bit rd, input logic [31:0] a, input logic [127:0] w);
        req_rd = rd; req_addr = a; req_wdata = w; start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic wait_strobe_low(output int n);
        n = 1;
        while (strobe_n && n < 60) begin tick(); n++; end
    endtask

    task automatic run_txn(input bit rd, input int lat, input int hold);
        logic [31:0]  a;
        logic [127:0] w, r;
        int n, m, k;
        a = 32'h1000_0000 + 32'(lat * 16) + 32'(rd);
        w = {a, ~a, a ^ 32'h5A5A_A5A5, 32'(lat * 7 + 3)};
        r = {32'(lat + 100), a ^ 32'hFFFF_0000, ~w[31:0], 32'hC0DE_0000 | 32'(lat)};
        issue(rd, a, w);
        chk(busy == 1'b1, "R2 busy", 128'(busy), 128'(1));
        chk(bus_addr == a, "R2 bus_addr", 128'(bus_addr), 128'(a));
        chk(bus_rd == rd, "R2 bus_rd", 128'(bus_rd), 128'(rd));
        chk(bus_drive == !rd, "R2 bus_drive", 128'(bus_drive), 128'(!rd));
        chk(bus_wdata == (rd ? 128'd0 : w), "R2 bus_wdata", bus_wdata, rd ? 128'd0 : w);
        wait_strobe_low(n);
        chk(n == 1 + SETUP, "R3 setup clocks", 128'(n), 128'(1 + SETUP));
        for (int i = 0; i < lat; i++) tick();
        chk(bus_addr == a && !strobe_n, "R3 addr held under strobe", 128'(bus_addr), 128'(a));
        ack_n = 1'b0; bus_rdata = r;
        m = 0;
        while (!strobe_n && m < 60) begin tick(); m++; end
        chk(m == 3, "R5 strobe rise after ack", 128'(m), 128'(3));
        for (int i = 0; i < hold; i++) begin
            chk(release_ok == 1'b0 && done == 1'b0, "R8 held ack blocks release",
                128'(release_ok), 128'(0));
            tick();
        end
        ack_n = 1'b1; bus_rdata = '0;
        k = 0;
        while (!done && k < 60) begin
            chk(release_ok == 1'b0, "R8 release low before done", 128'(release_ok), 128'(0));
            tick(); k++;
        end
        chk(k == 3, "R7 done latency", 128'(k), 128'(3));
        chk(busy == 1'b0, "R7 busy clear", 128'(busy), 128'(0));
        chk(err == 1'b0, "R9 no err on success", 128'(err), 128'(0));
        if (rd) last_rd = r;
        chk(rd_data == last_rd, "R6 rd_data", rd_data, last_rd);
        tick();
        chk(done == 1'b0, "R7 done one clock", 128'(done), 128'(0));
        chk(release_ok == 1'b1, "R8 release in idle", 128'(release_ok), 128'(1));
    endtask

    initial begin
        int n, m;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk(strobe_n == 1'b1, "R1 strobe_n", 128'(strobe_n), 128'(1));
        chk(bus_drive == 1'b0 && busy == 1'b0, "R1 drive/busy", 128'({bus_drive, busy}), 128'(0));
        chk(done == 1'b0 && err == 1'b0, "R1 done/err", 128'({done, err}), 128'(0));
        chk(release_ok == 1'b1, "R1 release_ok", 128'(release_ok), 128'(1));

        // latency x direction sweep
        for (int lat = 0; lat <= TMO - 3; lat++)
            for (int rd = 0; rd < 2; rd++)
                run_txn(rd[0], lat, (lat + rd) % 4);

        // R9 timeout with silent slave
        issue(1'b1, 32'hDEAD_0004, '0);
        wait_strobe_low(n);
        m = 0;
        while (!strobe_n && m < 60) begin tick(); m++; end
        chk(m == TMO, "R9 strobe low length", 128'(m), 128'(TMO));
        tick();
        chk(done == 1'b1 && err == 1'b1, "R9 done with err", 128'({done, err}), 128'(3));
        chk(rd_data == last_rd, "R6 timeout keeps rd_data", rd_data, last_rd);
        tick();

        // R4 ack held low across start
        ack_n = 1'b0;
        repeat (4) tick();
        chk(release_ok == 1'b0, "R8 stray ack blocks release", 128'(release_ok), 128'(0));
        issue(1'b0, 32'h0000_0400, 128'h1234);
        repeat (4) tick();
        chk(strobe_n == 1'b1, "R4 strobe held off", 128'(strobe_n), 128'(1));
        ack_n = 1'b1;
        m = 0;
        while (strobe_n && m < 60) begin tick(); m++; end
        chk(m == 3, "R4 strobe after ack release", 128'(m), 128'(3));
        tick();
        // R11 start while busy
        issue(1'b1, 32'hFFFF_FFFF, '1);
        chk(bus_addr == 32'h0000_0400 && bus_rd == 1'b0, "R11 start ignored",
            128'(bus_addr), 128'(32'h0000_0400));
        // R10 bus clear mid-cycle
        bus_clr = 1'b1;
        #1;
        chk(strobe_n == 1'b1 && bus_drive == 1'b0, "R10 immediate drop",
            128'({strobe_n, bus_drive}), 128'(2));
        chk(bus_addr == 32'd0 && bus_rd == 1'b0, "R10 addr cleared", 128'(bus_addr), 128'(0));
        tick();
        bus_clr = 1'b0;
        chk(busy == 1'b0 && done == 1'b0, "R10 idle no done", 128'({busy, done}), 128'(0));
        repeat (5) begin
            tick();
            chk(done == 1'b0 && strobe_n == 1'b1, "R10 stays quiet", 128'({done, strobe_n}), 128'(1));
        end
        run_txn(1'b1, 1, 0);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 20000, 0);
        finish_run();
    end
endmodule